// File: doc/BRIEF.md
# Dual-Bank Synchronous Clock Divider

This block takes one fast input clock and produces two divided clocks, bank A and bank B. Both come from dividers that share the same clock, clock enable and reset. As a result, a rising edge that both outputs have in common falls on the same input edge. Bank A divides by 2 or 4. Bank B divides by 4, 5 or 6. Divide by 5 uses only rising-edge logic, so its output is high for three input periods and low for two.

The hold input stops both banks without cutting a pulse short. Hold is captured on the falling input edge, so the dividers only start or stop while the clock is low. A master reset acts at once and drives every divided output low. Its release is synchronised, so several instances that share the reset start their first periods on the same input edge. When a select input changes, the new ratio takes effect at the next period boundary of that bank. The pulse already in progress is never truncated. If complementary outputs are enabled, each bank also drives an inverted copy of its clock.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: Bank A divides by 2 when `sel_a_i` is 0 and by 4 when it is 1, with a 50% duty cycle. All-zero select inputs give divide by 2 on bank A and divide by 4 on bank B.
- R2: The bank B ratio is decoded from {`sel_b_i[1]`,`sel_b_i[0]`}: 2'b00 divides by 4 and 2'b01 divides by 6, both at 50% duty. 2'b10 and 2'b11 both divide by 5, with the output high for 3 input periods and low for 2.
- R3: While hold is in effect, both banks keep their outputs and their count state unchanged. When hold is removed, each bank continues from the phase where it stopped.
- R4: `hold_i` is sampled on the falling edge of `clk_i`. A value driven during the high phase acts from the next rising edge onward.
- R5: While `mreset_i` is high, both divided outputs are low, and this takes effect without waiting for a clock edge.
- R6: After `mreset_i` falls, both outputs stay low for two rising edges. On the third rising edge, both banks rise together, and that edge starts their first periods.
- R7: A change of select applies at the next period boundary of the affected bank. The period in progress finishes with its old high and low lengths.
- R8: With `COMPL_EN` set to 1, each `*_clk_n_o` output is the inverse of its bank clock at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| mreset_i | input | 1 | Master reset, active high, asynchronous assert |
| hold_i | input | 1 | 1 freezes both banks, 0 lets them divide |
| sel_a_i | input | 1 | Bank A ratio select |
| sel_b_i | input | 2 | Bank B ratio select |
| a_clk_o | output | 1 | Bank A divided clock |
| a_clk_n_o | output | 1 | Bank A complement (low when COMPL_EN is 0) |
| b_clk_o | output | 1 | Bank B divided clock |
| b_clk_n_o | output | 1 | Bank B complement (low when COMPL_EN is 0) |

## Verification
A countdown value or a latched ratio that is wrong shows up at the pins within one output period. It appears either as a high or low run of the wrong length or as a rising edge missing from the boundary where it belongs. A hold flop that samples on the wrong edge moves the freeze one input cycle, so a pin value two ticks after hold is applied already shows the error. Alignment faults between the banks appear on the third edge after reset release, where both outputs must rise together.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  parameter int DIV_W = 3;

  typedef logic [DIV_W-1:0] ratio_t;

  function automatic ratio_t ratio_bank_a(input logic sel);
    return sel ? ratio_t'(4) : ratio_t'(2);
  endfunction

  function automatic ratio_t ratio_bank_b(input logic [1:0] sel);
    ratio_t r;
    case (sel)
      2'b00:   r = ratio_t'(4);
      2'b01:   r = ratio_t'(6);
      default: r = ratio_t'(5);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic mreset_i,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or posedge mreset_i) begin
    if (mreset_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/clkdiv_hold_capture.sv
module clkdiv_hold_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic run_o
);

  logic run_q;
  logic run_d;

  always_comb begin
    run_d = ~hold_i;
  end

  // Falling-edge capture: the run flag only changes while clk_i is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b1;
    end else begin
      run_q <= run_d;
    end
  end

  assign run_o = run_q;

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  ratio_t ratio_i,
  output logic   clk_o
);

  ratio_t cnt_q, cnt_d;
  ratio_t ratio_q, ratio_d;
  logic   out_q, out_d;
  logic   boundary;

  assign boundary = (cnt_q == '0);

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    out_d   = out_q;
    if (en_i) begin
      if (boundary) begin
        ratio_d = ratio_i;
        cnt_d   = ratio_i - ratio_t'(1);
        out_d   = 1'b1;
      end else begin
        cnt_d = cnt_q - ratio_t'(1);
        out_d = (cnt_d >= (ratio_q >> 1));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= ratio_t'(2);
      out_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      out_q   <= out_d;
    end
  end

  assign clk_o = out_q;

  assert_hold_freezes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(out_q) && $stable(cnt_q));

  assert_boundary_rises_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && boundary) |=> out_q);

  assert_cnt_in_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_low_R5: assert (!out_q);
    end
  end

endmodule

// File: rtl/dual_bank_clkdiv.sv
module dual_bank_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int COMPL_EN    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       mreset_i,
  input  logic       hold_i,
  input  logic       sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       a_clk_o,
  output logic       a_clk_n_o,
  output logic       b_clk_o,
  output logic       b_clk_n_o
);

  localparam int NUM_BANKS = 2;

  logic   rst_n;
  logic   run;
  ratio_t ratio   [NUM_BANKS];
  logic   div_clk [NUM_BANKS];

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i    (clk_i),
    .mreset_i (mreset_i),
    .rst_no   (rst_n)
  );

  clkdiv_hold_capture i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .hold_i (hold_i),
    .run_o  (run)
  );

  assign ratio[0] = ratio_bank_a(sel_a_i);
  assign ratio[1] = ratio_bank_b(sel_b_i);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    clkdiv_bank i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .en_i    (run),
      .ratio_i (ratio[g]),
      .clk_o   (div_clk[g])
    );
  end

  assign a_clk_o = div_clk[0];
  assign b_clk_o = div_clk[1];

  if (COMPL_EN != 0) begin : g_compl
    assign a_clk_n_o = ~div_clk[0];
    assign b_clk_n_o = ~div_clk[1];
  end else begin : g_no_compl
    assign a_clk_n_o = 1'b0;
    assign b_clk_n_o = 1'b0;
  end

  assert_release_together_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(rst_n) |=> (div_clk[0] == div_clk[1]));

endmodule

// File: tb/test_dual_bank_clkdiv.sv
module test_dual_bank_clkdiv;

  logic       clk = 1'b0;
  logic       mreset;
  logic       hold;
  logic       sel_a;
  logic [1:0] sel_b;
  logic       a_clk, a_clk_n, b_clk, b_clk_n;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  dual_bank_clkdiv i_dual_bank_clkdiv (
    .clk_i     (clk),
    .mreset_i  (mreset),
    .hold_i    (hold),
    .sel_a_i   (sel_a),
    .sel_b_i   (sel_b),
    .a_clk_o   (a_clk),
    .a_clk_n_o (a_clk_n),
    .b_clk_o   (b_clk),
    .b_clk_n_o (b_clk_n)
  );

  // {sel_a, sel_b[1:0], bank A ticks 1..14, bank B ticks 1..14}, first tick in MSB
  localparam int NV = 4;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 2'b00, 14'b00101010101010, 14'b00110011001100},
    {1'b1, 2'b01, 14'b00110011001100, 14'b00111000111000},
    {1'b0, 2'b10, 14'b00101010101010, 14'b00111001110011},
    {1'b1, 2'b11, 14'b00110011001100, 14'b00111001110011}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // enter reset with the given selects, then release it after one tick
  task automatic restart(input logic sa, input logic [1:0] sb);
    mreset = 1'b1; hold = 1'b0; sel_a = sa; sel_b = sb;
    tick();
    mreset = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    mreset = 1'b1; hold = 1'b0; sel_a = 1'b0; sel_b = 2'b00;
    tick(); tick();
    // R5 reset state; R8 complements inverted
    check("R5 reset state", {14'b0, a_clk, b_clk}, 16'b0);
    check("R8 complements in reset", {14'b0, a_clk_n, b_clk_n}, 16'b11);

    // vector walk: R1, R2 ratios and duty, R6 release timing and alignment, R8
    for (int v = 0; v < NV; v++) begin
      logic [13:0] got_a, got_b;
      logic        comp_bad;
      comp_bad = 1'b0;
      restart(VEC[v][30], VEC[v][29:28]);
      for (int t = 0; t < 14; t++) begin
        tick();
        got_a[13-t] = a_clk;
        got_b[13-t] = b_clk;
        if ((a_clk_n !== ~a_clk) || (b_clk_n !== ~b_clk)) comp_bad = 1'b1;
      end
      check("R1 R6 bank A waveform", {2'b0, got_a}, {2'b0, VEC[v][27:14]});
      check("R2 R6 bank B waveform", {2'b0, got_b}, {2'b0, VEC[v][13:0]});
      check("R8 complement tracking", {15'b0, comp_bad}, 16'b0);
    end

    // R5: asynchronous effect of reset while both outputs are high
    restart(1'b0, 2'b00);
    tick(); tick(); tick();
    check("R6 both high at first edge", {14'b0, a_clk, b_clk}, 16'b11);
    mreset = 1'b1;
    #0.5;
    check("R5 async reset drop", {14'b0, a_clk, b_clk}, 16'b0);

    // R3 / R4: hold freeze and resume (A div2, B div4)
    restart(1'b0, 2'b00);
    for (int t = 0; t < 5; t++) tick();
    check("R3 pre-hold state", {14'b0, a_clk, b_clk}, 16'b10);
    hold = 1'b1;
    begin
      logic [3:0] fa, fb;
      for (int t = 0; t < 4; t++) begin
        tick();
        fa[3-t] = a_clk;
        fb[3-t] = b_clk;
      end
      check("R4 hold acts at next edge, R3 freeze A", {12'b0, fa}, 16'b1111);
      check("R3 freeze B", {12'b0, fb}, 16'b0000);
    end
    hold = 1'b0;
    tick();
    check("R3 R4 resume phase 1", {14'b0, a_clk, b_clk}, 16'b00);
    tick();
    check("R3 resume phase 2", {14'b0, a_clk, b_clk}, 16'b11);

    // R7: bank B switches from div4 to div6 mid-period
    restart(1'b0, 2'b00);
    tick(); tick(); tick();
    sel_b = 2'b01;
    begin
      logic [9:0] wb, wa;
      for (int t = 0; t < 10; t++) begin
        tick();
        wb[9-t] = b_clk;
        wa[9-t] = a_clk;
      end
      check("R7 select at boundary B", {6'b0, wb}, {6'b0, 10'b1001110001});
      check("R7 bank A unaffected", {6'b0, wa}, {6'b0, 10'b0101010101});
    end

    finish_run();
  end

endmodule